// File: doc/BRIEF.md
# Multiple-Register Transfer Address Sequencer

This block sequences the addresses for a block load or store that moves a chosen set of registers to or from consecutive memory words. A request carries a 16-bit register bitmask, a 32-bit base address and a two-bit addressing mode. Once a request is accepted, the block issues one register number and one word address per handshake on its transfer port. When the last transfer is taken, it pulses a completion flag together with the updated base value, which the surrounding core may write back or discard.

Registers always leave in ascending number order, and the lowest-numbered register always gets the lowest address. The mode selects the direction (upward or downward from the base) and whether the base is adjusted ahead of the first access or after the last. Downward modes therefore start below the base, so that the addresses still climb by one word per register. The data path and the register file sit outside this block.

Top module: `mreg_addr_seq`

## Requirements
- R1: Out of reset the block is idle: `req_ready`=1, `xfer_valid`=0, `done`=0. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1.
- R2: An accepted request produces exactly as many transfer handshakes as there are set bits in `req_list`, and `xfer_valid` stays high from acceptance until the last of them.
- R3: Transfers name the set register indices in strictly ascending order on `xfer_reg`.
- R4: Each transfer address is 4 higher than the one before it, so the k-th transfer (from 0) uses start+4k, wrapping modulo 2^32.
- R5: Mode 2'b00 (upward, adjust after): the first address equals the base.
- R6: Mode 2'b01 (upward, adjust before): the first address equals base+4.
- R7: Mode 2'b10 (downward, adjust after): the first address equals base−4·n+4, where n is the number of set bits.
- R8: Mode 2'b11 (downward, adjust before): the first address equals base−4·n.
- R9: While `done` is high, `final_base` equals base+4·n for modes 00 and 01, and base−4·n for modes 10 and 11.
- R10: `done` rises in the cycle after the last transfer handshake, lasts exactly one cycle, and the block is idle in the cycle after it.
- R11: An empty register list produces no transfer; `done` is high in the cycle after acceptance, and `final_base` equals the base.
- R12: `req_ready` stays low from acceptance until `done` has been signalled, so a request presented in that time is ignored and does not change the transfers or the final base.
- R13: While `xfer_valid` is high and `xfer_ready` is low, `xfer_reg` and `xfer_addr` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, can take a request |
| req_list | input | 16 | Register bitmask, bit i selects register i |
| req_base | input | 32 | Base byte address |
| req_mode | input | 2 | Bit 1: downward; bit 0: adjust before access |
| xfer_valid | output | 1 | Transfer offered |
| xfer_ready | input | 1 | Transfer taken |
| xfer_reg | output | 4 | Register index of the current transfer |
| xfer_addr | output | 32 | Word address of the current transfer |
| done | output | 1 | One-cycle completion pulse |
| final_base | output | 32 | Updated base, valid while done is high |

## Verification
On every cycle, the assertions check the handshake discipline: ready and a busy sequence are never both present, values hold during a stall, the address steps by one word, the register index climbs, done lasts one cycle, and an empty list finishes at once with the base unchanged. Only the bench scenarios can show that the start address matches each of the four modes, that the number of transfers equals the bit count of a sparse mask, and that the written-back base is correct. These depend on the whole request and not on adjacent cycles.

// File: rtl/mreg_addr_seq.sv
module mreg_addr_seq #(
  parameter int NREG = 16,
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [NREG-1:0]          req_list,
  input  logic [AW-1:0]            req_base,
  input  logic [1:0]               req_mode,
  output logic                     xfer_valid,
  input  logic                     xfer_ready,
  output logic [$clog2(NREG)-1:0]  xfer_reg,
  output logic [AW-1:0]            xfer_addr,
  output logic                     done,
  output logic [AW-1:0]            final_base
);
  localparam int RW = $clog2(NREG);
  localparam int CW = $clog2(NREG + 1);
  localparam logic [AW-1:0] STEPW = AW'(STEP);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_t;

  st_t             st;
  logic [NREG-1:0] left;
  logic [AW-1:0]   addr, fin;
  logic [CW-1:0]   cnt;
  logic [RW-1:0]   low;
  logic [AW-1:0]   span, start, upd;
  logic            take, last, dn, bf;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NREG; i++) cnt = cnt + CW'(req_list[i]);
  end

  always_comb begin
    low = '0;
    for (int i = NREG - 1; i >= 0; i--) if (left[i]) low = RW'(i);
  end

  assign dn    = req_mode[1];
  assign bf    = req_mode[0];
  assign span  = AW'(cnt) * STEPW;
  assign start = dn ? (req_base - span + (bf ? '0 : STEPW))
                    : (req_base + (bf ? STEPW : '0));
  assign upd   = dn ? (req_base - span) : (req_base + span);
  assign take  = req_valid && req_ready;
  assign last  = (left & (left - 1'b1)) == '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      left <= '0;
      addr <= '0;
      fin  <= '0;
    end else begin
      case (st)
        S_IDLE: if (take) begin
          left <= req_list;
          addr <= start;
          fin  <= upd;
          st   <= (req_list == '0) ? S_FIN : S_RUN;
        end
        S_RUN: if (xfer_ready) begin
          left <= left & (left - 1'b1);
          addr <= addr + STEPW;
          if (last) st <= S_FIN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready  = (st == S_IDLE);
  assign xfer_valid = (st == S_RUN);
  assign done       = (st == S_FIN);
  assign xfer_reg   = low;
  assign xfer_addr  = addr;
  assign final_base = fin;
endmodule

// File: rtl/mreg_addr_seq_chk.sv
module mreg_addr_seq_chk #(
  parameter int NREG = 16,
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic                    req_ready,
  input logic [NREG-1:0]         req_list,
  input logic [AW-1:0]           req_base,
  input logic                    xfer_valid,
  input logic                    xfer_ready,
  input logic [$clog2(NREG)-1:0] xfer_reg,
  input logic [AW-1:0]           xfer_addr,
  input logic                    done,
  input logic [AW-1:0]           final_base
);
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid || done) |-> !req_ready); // R12
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ready) |=> (xfer_valid && $stable(xfer_addr) && $stable(xfer_reg))); // R13
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_ready) |=> (!xfer_valid || xfer_addr == $past(xfer_addr) + AW'(STEP))); // R4
  AST_REG_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_ready) |=> (!xfer_valid || xfer_reg > $past(xfer_reg))); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready)); // R10
  AST_EMPTY_LIST: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_list == '0) |=> (done && !xfer_valid && final_base == $past(req_base))); // R11
  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_list != '0) |=> xfer_valid); // R2
endmodule

bind mreg_addr_seq mreg_addr_seq_chk #(.NREG(NREG), .AW(AW), .STEP(STEP)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_list(req_list), .req_base(req_base), .xfer_valid(xfer_valid),
  .xfer_ready(xfer_ready), .xfer_reg(xfer_reg), .xfer_addr(xfer_addr),
  .done(done), .final_base(final_base)
);

// File: tb/sim_mreg_addr_seq.sv
module sim_mreg_addr_seq;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [15:0] req_list = '0;
  logic [31:0] req_base = '0;
  logic [1:0]  req_mode = '0;
  logic        xfer_valid, xfer_ready = 1'b0;
  logic [3:0]  xfer_reg;
  logic [31:0] xfer_addr;
  logic        done;
  logic [31:0] final_base;
  int errs = 0, checks = 0;

  always #4 clk = ~clk;

  mreg_addr_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_list(req_list), .req_base(req_base), .req_mode(req_mode),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_reg(xfer_reg),
    .xfer_addr(xfer_addr), .done(done), .final_base(final_base)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int popc(input logic [15:0] l);
    int n = 0;
    for (int i = 0; i < 16; i++) n += int'(l[i]);
    return n;
  endfunction

  function automatic int nth_reg(input logic [15:0] l, input int k);
    int seen = 0;
    for (int i = 0; i < 16; i++)
      if (l[i]) begin
        if (seen == k) return i;
        seen++;
      end
    return -1;
  endfunction

  function automatic logic [31:0] first_addr(input logic [31:0] b, input int n, input logic [1:0] m);
    case (m)
      2'b00: return b;
      2'b01: return b + 32'd4;
      2'b10: return b - 32'(4 * n) + 32'd4;
      default: return b - 32'(4 * n);
    endcase
  endfunction

  function automatic logic [31:0] new_base(input logic [31:0] b, input int n, input logic [1:0] m);
    return m[1] ? b - 32'(4 * n) : b + 32'(4 * n);
  endfunction

  task automatic run(input logic [15:0] l, input logic [31:0] b, input logic [1:0] m, input int pct);
    int n = popc(l);
    int k = 0;
    int guard = 0;
    bit seen_done = 0, prev_hs = 0, prev_stall = 0;
    logic [31:0] a0 = first_addr(b, n, m);
    string mtag;
    case (m)
      2'b00: mtag = "R5";
      2'b01: mtag = "R6";
      2'b10: mtag = "R7";
      default: mtag = "R8";
    endcase
    @(negedge clk);
    chk(req_ready === 1'b1, "R1", "ready when idle", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_list = l; req_base = b; req_mode = m;
    @(negedge clk);
    req_list = 16'($urandom); req_base = $urandom; req_mode = 2'($urandom);
    while (!seen_done && guard < 400) begin
      guard++;
      if (done) begin
        seen_done = 1;
        req_valid = 1'b0;
        xfer_ready = 1'b0;
        chk(k == n, "R2", "transfer count", 32'(k), 32'(n));
        chk(final_base == new_base(b, n, m), "R9", "final base", final_base, new_base(b, n, m));
        if (n == 0) chk(guard == 1, "R11", "empty list done delay", 32'(guard), 32'd1);
        else chk(prev_hs, "R10", "done after last handshake", 32'(prev_hs), 32'd1);
      end else begin
        chk(!req_ready, "R12", "ready low while busy", 32'(req_ready), 32'd0);
        if (xfer_valid && k < n) begin
          chk(32'(xfer_reg) == 32'(nth_reg(l, k)), prev_stall ? "R13" : "R3", "register index",
              32'(xfer_reg), 32'(nth_reg(l, k)));
          chk(xfer_addr == a0 + 32'(4 * k), prev_stall ? "R13" : (k == 0 ? mtag : "R4"),
              "transfer address", xfer_addr, a0 + 32'(4 * k));
          xfer_ready = (($urandom % 100) < 32'(pct));
          prev_hs = xfer_ready;
          prev_stall = !xfer_ready;
          if (xfer_ready) k++;
        end else begin
          chk(0, "R2", "busy without transfer or extra transfer", 32'(k), 32'(n));
          xfer_ready = 1'b0;
          prev_hs = 0;
        end
      end
      @(negedge clk);
    end
    if (!seen_done) chk(0, "R10", "done never seen", 32'd0, 32'd1);
    chk(!done && req_ready, "R10", "done one cycle then idle", 32'({done, req_ready}), 32'b01);
  endtask

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk);
    chk(req_ready && !xfer_valid && !done, "R1", "reset state",
        32'({req_ready, xfer_valid, done}), 32'b100);
    @(negedge clk);
    rst_n = 1'b1;
    for (int m = 0; m < 4; m++) begin
      run(16'hFFFF, 32'h0000_1000, 2'(m), 100);
      run(16'h8001, 32'h0000_2000, 2'(m), 50);
      run(16'h0000, 32'h1234_5678, 2'(m), 70);
      run(16'h0400, 32'h0000_0008, 2'(m), 30);
      run(16'h5A3C, 32'hFFFF_FFF8, 2'(m), 70);
    end
    for (int i = 0; i < 60; i++) begin
      logic [15:0] l = 16'($urandom);
      if (i % 7 == 0) l = l & 16'($urandom);
      run(l, $urandom & 32'hFFFF_FFFC, 2'($urandom), 40 + int'($urandom % 61));
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    errs++; checks++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule